// File: doc/BRIEF.md
# GF(2) Quadratic System Evaluator

This block computes a vector of multivariate quadratic forms over GF(2) at one input point. With the default parameters it takes an 84-bit vector `x` and produces 98 output bits. Each output bit is the value of a polynomial with 3,655 coefficient bits, and the whole coefficient image has 358,190 bits. This is the public-key encryption step of a quadratic multivariate scheme: the plaintext goes in as `x` and the ciphertext comes out as `y`.

The coefficients stay in an external memory. The block walks through that memory with an address output, and each word comes back on a data input a fixed number of cycles later. Every fetched word is ANDed with the matching slice of the monomial vector, which is built combinationally from the latched input. A wide XOR tree reduces the product into a running parity bit. When a polynomial's last word has been accumulated, its parity is stored and the parity restarts for the next polynomial. A request is accepted with `start` while `ready` is high. A one-cycle `done` pulse marks the cycle in which the new `y` appears.

Top module: `mq_quad_eval`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, `coef_req` is 0 and `y_out` is all zeros.
- R2: `start` is taken only while `ready` is 1. The cycle after an accepted start, `ready` drops. A `start` seen while `ready` is 0 is ignored: it does not relatch the input and it does not change the result.
- R3: An accepted start raises `coef_req` for the next NPOLY*NCHUNK consecutive cycles. During those cycles `coef_addr` counts up by one from 0. `coef_req` is 0 at every other time.
- R4: Coefficient layout. The coefficient bit at position b of polynomial p is bit (b mod CHUNK_W) of the memory word at address p*NCHUNK + b div CHUNK_W. Positions are ordered as follows: products x_i*x_j with i ≤ j in row-major order (i outer, j inner), then the linear terms x_0..x_{N-1}, then the constant. Positions past the last coefficient in the final word of a polynomial are ignored.
- R5: Bit k of `y_out` equals polynomial k: the XOR over all positions of (coefficient AND monomial).
- R6: A square position (i = j) multiplies its coefficient by x_i itself.
- R7: `done` is a single-cycle pulse. It is 1 exactly NPOLY*NCHUNK + RD_LAT + 1 cycles after the edge that accepted `start`, which is 493 with the defaults. `ready` returns to 1 in that same cycle.
- R8: `y_out` changes only in a cycle where `done` is 1, and otherwise holds its value.
- R9: With an all-zero input, each output bit equals the constant coefficient of its polynomial.
- R10: The parity restarts at every polynomial boundary, so no polynomial's result depends on another polynomial's coefficients.
- R11: Read data is used exactly RD_LAT cycles after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to evaluate `x_in` |
| x_in | input | NVAR (84) | Input vector, sampled when start is accepted |
| ready | output | 1 | High while idle; a start is accepted |
| coef_req | output | 1 | `coef_addr` is a valid read this cycle |
| coef_addr | output | AW (9) | Coefficient word address |
| coef_data | input | CHUNK_W (731) | Coefficient word, RD_LAT cycles after its address |
| done | output | 1 | One-cycle pulse: `y_out` has just been updated |
| y_out | output | NPOLY (98) | Result vector, bit k is polynomial k |

## Verification
With random coefficients, the layout of a single position inside the 3,655-bit string is hard to see from the ports: a misplaced square term or an off-by-one slice still produces bits that look random. The bench therefore loads sparse coefficient images. One image sets only the (0,83) product in one polynomial, a linear term in a second and the constant in a third. Another sets only one square term in every polynomial. With these images each expected output is known by hand. A second case that is hard to reach is a start arriving mid-evaluation. The bench drives it with a different vector about a hundred cycles into a run, then checks that both the address stream and the result are unchanged.

// File: rtl/mq_eval_pkg.sv
package mq_eval_pkg;

    localparam int DEF_NVAR    = 84;
    localparam int DEF_NPOLY   = 98;
    localparam int DEF_CHUNK_W = 731;
    localparam int DEF_RD_LAT  = 2;

    // Number of coefficient positions of one polynomial in NVAR variables.
    function automatic int mono_count(input int nvar);
        return nvar * (nvar + 1) / 2 + nvar + 1;
    endfunction

    // First flat position of row i of the i <= j product triangle.
    function automatic int row_base(input int nvar, input int i);
        return i * nvar - (i * (i - 1)) / 2;
    endfunction

endpackage

// File: rtl/mq_monomial_expand.sv
module mq_monomial_expand #(
    parameter int NVAR  = 84,
    parameter int PAD_W = 3655
) (
    input  logic [NVAR-1:0]  x,
    output logic [PAD_W-1:0] mono
);
    import mq_eval_pkg::*;

    localparam int QUAD_N = NVAR * (NVAR + 1) / 2;
    localparam int MONO_N = QUAD_N + NVAR + 1;

    for (genvar i = 0; i < NVAR; i++) begin : g_row
        for (genvar j = i; j < NVAR; j++) begin : g_col
            localparam int POS = row_base(NVAR, i) + j - i;
            if (i == j) begin : g_sq
                assign mono[POS] = x[i];
            end else begin : g_cross
                assign mono[POS] = x[i] & x[j];
            end
        end
        assign mono[QUAD_N + i] = x[i];
    end

    assign mono[MONO_N-1] = 1'b1;

    if (PAD_W > MONO_N) begin : g_pad
        assign mono[PAD_W-1:MONO_N] = '0;
    end

endmodule

// File: rtl/mq_slice_reduce.sv
module mq_slice_reduce #(
    parameter int CHUNK_W = 731,
    parameter int NCHUNK  = 5,
    parameter int CW      = 3
) (
    input  logic [NCHUNK*CHUNK_W-1:0] mono,
    input  logic [CW-1:0]             sel,
    input  logic [CHUNK_W-1:0]        coef,
    output logic                      parity
);
    logic [CHUNK_W-1:0] slice;

    always_comb begin
        slice  = mono[int'(sel) * CHUNK_W +: CHUNK_W];
        parity = ^(slice & coef);
    end

endmodule

// File: rtl/mq_fetch_seq.sv
module mq_fetch_seq #(
    parameter int NCHUNK = 5,
    parameter int NPOLY  = 98,
    parameter int RD_LAT = 2,
    parameter int AW     = 9,
    parameter int CW     = 3,
    parameter int PW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          req,
    output logic [AW-1:0] addr,
    output logic          tag_vld,
    output logic [CW-1:0] tag_chunk,
    output logic [PW-1:0] tag_poly
);
    localparam int TOTAL = NPOLY * NCHUNK;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] chunk;
        logic [PW-1:0] poly;
        logic [AW-1:0] addr;
    } seq_t;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] chunk;
        logic [PW-1:0] poly;
    } tag_t;

    seq_t s_d, s_q;
    tag_t pipe_d [RD_LAT];
    tag_t pipe_q [RD_LAT];

    always_comb begin
        s_d = s_q;
        if (go && !s_q.active) begin
            s_d.active = 1'b1;
            s_d.chunk  = '0;
            s_d.poly   = '0;
            s_d.addr   = '0;
        end else if (s_q.active) begin
            s_d.addr = s_q.addr + AW'(1);
            if (s_q.chunk == CW'(NCHUNK - 1)) begin
                s_d.chunk = '0;
                if (s_q.poly == PW'(NPOLY - 1)) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.poly = s_q.poly + PW'(1);
                end
            end else begin
                s_d.chunk = s_q.chunk + CW'(1);
            end
        end

        pipe_d[0] = '{vld: s_q.active, chunk: s_q.chunk, poly: s_q.poly};
        for (int k = 1; k < RD_LAT; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int k = 0; k < RD_LAT; k++) pipe_q[k] <= '0;
        end else begin
            s_q <= s_d;
            for (int k = 0; k < RD_LAT; k++) pipe_q[k] <= pipe_d[k];
        end
    end

    assign req       = s_q.active;
    assign addr      = s_q.addr;
    assign tag_vld   = pipe_q[RD_LAT-1].vld;
    assign tag_chunk = pipe_q[RD_LAT-1].chunk;
    assign tag_poly  = pipe_q[RD_LAT-1].poly;

    // R3: a read stream opens at address 0
    a_r3_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> addr == '0);

    // R3: consecutive reads step by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> addr == $past(addr) + AW'(1));

    // R3: no address beyond the coefficient image
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> int'(addr) < TOTAL);

    // R11: the returned tag is never ahead of the last issued read
    a_r11_tag_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_vld) |-> tag_chunk == '0 && tag_poly == '0);

endmodule

// File: rtl/mq_quad_eval.sv
module mq_quad_eval
    import mq_eval_pkg::*;
#(
    parameter int NVAR    = DEF_NVAR,
    parameter int NPOLY   = DEF_NPOLY,
    parameter int CHUNK_W = DEF_CHUNK_W,
    parameter int RD_LAT  = DEF_RD_LAT,
    localparam int MONO_N = mono_count(NVAR),
    localparam int NCHUNK = (MONO_N + CHUNK_W - 1) / CHUNK_W,
    localparam int PAD_W  = NCHUNK * CHUNK_W,
    localparam int TOTAL  = NPOLY * NCHUNK,
    localparam int AW     = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int PW     = (NPOLY > 1) ? $clog2(NPOLY) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NVAR-1:0]    x_in,
    output logic               ready,
    output logic               coef_req,
    output logic [AW-1:0]      coef_addr,
    input  logic [CHUNK_W-1:0] coef_data,
    output logic               done,
    output logic [NPOLY-1:0]   y_out
);

    typedef struct packed {
        logic             busy;
        logic [NVAR-1:0]  x;
        logic             acc;
        logic [NPOLY-1:0] work;
        logic [NPOLY-1:0] y;
        logic             done;
    } core_t;

    core_t c_d, c_q;

    logic             go;
    logic [PAD_W-1:0] mono;
    logic             tag_vld;
    logic [CW-1:0]    tag_chunk;
    logic [PW-1:0]    tag_poly;
    logic             chunk_par;
    logic             poly_bit;

    assign go = start && !c_q.busy;

    mq_monomial_expand #(.NVAR(NVAR), .PAD_W(PAD_W)) u_expand (
        .x    (c_q.x),
        .mono (mono)
    );

    mq_fetch_seq #(
        .NCHUNK(NCHUNK), .NPOLY(NPOLY), .RD_LAT(RD_LAT),
        .AW(AW), .CW(CW), .PW(PW)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .req       (coef_req),
        .addr      (coef_addr),
        .tag_vld   (tag_vld),
        .tag_chunk (tag_chunk),
        .tag_poly  (tag_poly)
    );

    mq_slice_reduce #(.CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK), .CW(CW)) u_reduce (
        .mono   (mono),
        .sel    (tag_chunk),
        .coef   (coef_data),
        .parity (chunk_par)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        poly_bit = ((tag_chunk == '0) ? 1'b0 : c_q.acc) ^ chunk_par;

        if (go) begin
            c_d.busy = 1'b1;
            c_d.x    = x_in;
        end

        if (tag_vld) begin
            c_d.acc = poly_bit;
            if (tag_chunk == CW'(NCHUNK - 1)) begin
                c_d.work[tag_poly] = poly_bit;
                if (tag_poly == PW'(NPOLY - 1)) begin
                    c_d.y    = c_d.work;
                    c_d.done = 1'b1;
                    c_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ready = !c_q.busy;
    assign done  = c_q.done;
    assign y_out = c_q.y;

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the block is idle again when it reports completion
    a_r7_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R8: the result only moves on completion
    a_r8_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(y_out));

    // R3: no memory traffic while idle
    a_r3_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !coef_req);

    // R2: an accepted start closes the idle window
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

endmodule

// File: tb/mq_quad_eval_tb_top.sv
`timescale 1ns/1ps
module mq_quad_eval_tb_top;

    localparam int NV     = 84;
    localparam int NP     = 98;
    localparam int W      = 731;
    localparam int LAT    = 2;
    localparam int NCOEF  = NV * (NV + 1) / 2 + NV + 1;
    localparam int NCH    = (NCOEF + W - 1) / W;
    localparam int TOT    = NP * NCH;
    localparam int AWB    = $clog2(TOT);
    localparam int DONE_C = TOT + LAT + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [NV-1:0]  x_in = '0;
    logic           ready, coef_req, done;
    logic [AWB-1:0] coef_addr;
    logic [W-1:0]   coef_data;
    logic [NP-1:0]  y_out;

    int total = 0;
    int bad   = 0;

    logic [W-1:0]   mem [TOT];
    logic [AWB-1:0] apipe [LAT];

    always #2.5 clk = ~clk;

    mq_quad_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .ready(ready), .coef_req(coef_req), .coef_addr(coef_addr),
        .coef_data(coef_data), .done(done), .y_out(y_out)
    );

    // Memory with a fixed read latency of LAT cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) apipe[k] <= '0;
        end else begin
            apipe[0] <= coef_addr;
            for (int k = 1; k < LAT; k++) apipe[k] <= apipe[k-1];
        end
    end
    assign coef_data = mem[apipe[LAT-1]];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic get_coef(input int p, input int b);
        return mem[p * NCH + b / W][b % W];
    endfunction

    task automatic set_coef(input int p, input int b, input logic v);
        mem[p * NCH + b / W][b % W] = v;
    endtask

    // Position of product x_i*x_j (i <= j), counted by walking the order
    function automatic int pos_of(input int i, input int j);
        int b = 0;
        for (int a = 0; a < NV; a++)
            for (int c = a; c < NV; c++) begin
                if (a == i && c == j) return b;
                b++;
            end
        return -1;
    endfunction

    function automatic logic [NP-1:0] ref_eval(input logic [NV-1:0] xv);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            logic par = 1'b0;
            int   b   = 0;
            for (int i = 0; i < NV; i++)
                for (int j = i; j < NV; j++) begin
                    par ^= get_coef(p, b) & xv[i] & xv[j];
                    b++;
                end
            for (int i = 0; i < NV; i++) begin
                par ^= get_coef(p, b) & xv[i];
                b++;
            end
            par ^= get_coef(p, b);
            r[p] = par;
        end
        return r;
    endfunction

    task automatic fill_random();
        for (int a = 0; a < TOT; a++)
            for (int k = 0; k < W; k++) mem[a][k] = 1'($urandom);
    endtask

    task automatic fill_zero();
        for (int a = 0; a < TOT; a++) mem[a] = '0;
    endtask

    function automatic logic [NV-1:0] rand_x();
        return {$urandom, $urandom, $urandom};
    endfunction

    task automatic run_eval(input logic [NV-1:0] xv, input bit inject,
                            input logic [NP-1:0] exp_y, input string req);
        logic [NP-1:0] y_seen;
        @(negedge clk);
        chk(ready === 1'b1, "R2", "ready before start", 128'(ready), 128'(1));
        start = 1'b1;
        x_in  = xv;
        @(negedge clk);
        start = 1'b0;
        x_in  = ~xv;
        for (int c = 1; c <= DONE_C; c++) begin
            bit exp_req  = (c <= TOT);
            bit exp_done = (c == DONE_C);
            chk(coef_req === exp_req, "R3", "coef_req per cycle",
                128'(coef_req), 128'(exp_req));
            if (exp_req)
                chk(coef_addr === AWB'(c - 1), "R3", "coef_addr per cycle",
                    128'(coef_addr), 128'(c - 1));
            chk(done === exp_done, "R7", "done timing", 128'(done), 128'(exp_done));
            chk(ready === exp_done, "R2", "ready while busy", 128'(ready), 128'(exp_done));
            if (exp_done) begin
                chk(y_out === exp_y, req, "result vector", 128'(y_out), 128'(exp_y));
            end else begin
                start = (inject && c == 100);
                @(negedge clk);
                start = 1'b0;
            end
        end
        y_seen = y_out;
        @(negedge clk);
        chk(done === 1'b0, "R7", "done one cycle only", 128'(done), 128'(0));
        chk(y_out === y_seen, "R8", "result held", 128'(y_out), 128'(y_seen));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NV-1:0] xv;
        logic [NP-1:0] e;
        fill_random();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready === 1'b1, "R1", "ready after reset", 128'(ready), 128'(1));
        chk(done === 1'b0, "R1", "done after reset", 128'(done), 128'(0));
        chk(coef_req === 1'b0, "R1", "coef_req after reset", 128'(coef_req), 128'(0));
        chk(y_out === '0, "R1", "y after reset", 128'(y_out), 128'(0));

        // R9: zero input yields the constant coefficients
        for (int p = 0; p < NP; p++) e[p] = get_coef(p, NCOEF - 1);
        run_eval('0, 1'b0, e, "R9");

        // R5: all-one input
        run_eval('1, 1'b0, ref_eval('1), "R5");

        // R5 / R10: random inputs, back to back
        for (int t = 0; t < 3; t++) begin
            xv = rand_x();
            run_eval(xv, 1'b0, ref_eval(xv), "R10");
        end

        // R2: start while busy carries a different vector and is ignored
        xv = rand_x();
        run_eval(xv, 1'b1, ref_eval(xv), "R2");

        // R4 / R11: sparse image, one position per chosen polynomial
        fill_zero();
        set_coef(0, pos_of(0, NV - 1), 1'b1);
        set_coef(1, NV * (NV + 1) / 2, 1'b1);
        set_coef(NP - 1, NCOEF - 1, 1'b1);
        xv = '0; xv[0] = 1'b1; xv[NV-1] = 1'b1;
        e = '0; e[0] = 1'b1; e[1] = 1'b1; e[NP-1] = 1'b1;
        run_eval(xv, 1'b0, e, "R4");
        xv = '0; xv[0] = 1'b1;
        e = '0; e[1] = 1'b1; e[NP-1] = 1'b1;
        run_eval(xv, 1'b0, e, "R4");

        // R6: only the square of variable 5 is set in every polynomial
        fill_zero();
        for (int p = 0; p < NP; p++) set_coef(p, pos_of(5, 5), 1'b1);
        xv = '0; xv[5] = 1'b1;
        run_eval(xv, 1'b0, '1, "R6");
        xv = '1; xv[5] = 1'b0;
        run_eval(xv, 1'b0, '0, "R6");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule